// File: doc/BRIEF.md
# Multiplexed DAC Parameter Loader

This block sits between a processor write port and a bank of voice channels that share one control-voltage DAC. Software builds a 12-bit code from two byte writes: one byte carries the six low code bits in its upper six bits, and the other carries the six high code bits in its lower six bits. A separate write picks which of eight channel parameters the code is meant for. A channel takes the current (parameter, code) pair only when its select bit moves from 0 to 1.

A write to the chip-select register compares the new value with the old one. Every channel whose bit rises is loaded. A DAC byte write also reloads every channel whose select bit is currently low. The effect is the same as writing all ones and then the old select value back, and the select register itself stays unchanged. All channels loaded by one write cycle are reported together on a single registered load strobe. The strobe carries a channel mask, the parameter index and the code.

Top module: `dac_param_loader`

## Requirements
- R1: A DAC write with `dac_lsb`=1 replaces code bits 5:0 with `wr_data` bits 7:2 and leaves code bits 11:6 unchanged.
- R2: A DAC write with `dac_lsb`=0 replaces code bits 11:6 with `wr_data` bits 5:0 and leaves code bits 5:0 unchanged.
- R3: A parameter-index write stores `wr_data` bits 2:0 as the index that later loads carry.
- R4: A chip-select write stores `wr_data` bits 5:0. Each channel whose bit goes from 0 to 1 is set in the load mask.
- R5: Channels whose select bit falls or stays the same are not loaded by a chip-select write. If no bit rises, no strobe is produced.
- R6: After a DAC write, every channel whose select bit is 0 is set in the load mask, and the select register keeps its value.
- R7: A DAC write while all six select bits are 1 produces no load strobe.
- R8: After reset the select register is 0x3F, the code and index are 0, and `load_vld` is 0.
- R9: The load strobe is asserted for exactly the cycle after the write edge that caused it. It carries, in one mask, every channel loaded in that write cycle. It carries the index and code as updated by the writes of that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 8 | Write data bus |
| dac_wr | input | 1 | DAC byte write strobe |
| dac_lsb | input | 1 | Address LSB for DAC byte (1 = low code bits) |
| idx_wr | input | 1 | Parameter-index write strobe |
| sel_wr | input | 1 | Chip-select write strobe |
| load_vld | output | 1 | One-cycle load strobe |
| load_mask | output | 6 | Channels that take this load |
| load_idx | output | 3 | Parameter index for the load |
| load_code | output | 12 | 12-bit code for the load |

## Verification
The bench builds the block with its default parameters: six channels, a 12-bit code split 6/6 and an 8-entry index. With these values every channel-mask pattern, and both byte halves of the code, can be reached within a few hundred random writes. Random cycles mix all three strobes, including several strobes in the same cycle. This exercises the case where a select write and a DAC write combine into one mask. Directed steps cover the reset values, a DAC write with all select bits high, and select writes whose bits only fall.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_CODE_W = 12;
  localparam int unsigned DEF_LO_W   = 6;
  localparam int unsigned DEF_IDX_W  = 3;
  localparam int unsigned DEF_NCH    = 6;

  typedef enum logic {HALF_HI = 1'b0, HALF_LO = 1'b1} code_half_e;
endpackage

// File: rtl/dpl_code_reg.sv
module dpl_code_reg #(
  parameter int unsigned DATA_W = dpl_pkg::DEF_DATA_W,
  parameter int unsigned CODE_W = dpl_pkg::DEF_CODE_W,
  parameter int unsigned LO_W   = dpl_pkg::DEF_LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              half_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] code_nxt
);
  import dpl_pkg::*;
  localparam int unsigned HI_W = CODE_W - LO_W;

  function automatic logic [CODE_W-1:0] merge_byte(
    input logic [CODE_W-1:0] cur, input logic half, input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] r;
    r = cur;
    if (code_half_e'(half) == HALF_LO) r[LO_W-1:0] = d[DATA_W-1 -: LO_W];
    else                              r[CODE_W-1:LO_W] = d[HI_W-1:0];
    return r;
  endfunction

  always_comb code_nxt = wr_en ? merge_byte(code_q, half_sel, wr_data) : code_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) code_q <= '0;
    else        code_q <= code_nxt;

  assert_lo_keeps_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && half_sel |=> code_q[CODE_W-1:LO_W] == $past(code_q[CODE_W-1:LO_W]));
  assert_hi_keeps_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !half_sel |=> code_q[LO_W-1:0] == $past(code_q[LO_W-1:0]));
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(code_q));
endmodule

// File: rtl/dpl_sel_track.sv
module dpl_sel_track #(
  parameter int unsigned NCH = dpl_pkg::DEF_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_wr,
  input  logic           dac_wr,
  input  logic [NCH-1:0] sel_data,
  output logic [NCH-1:0] sel_q,
  output logic [NCH-1:0] rise_mask,
  output logic [NCH-1:0] reload_mask,
  output logic [NCH-1:0] ev_mask
);
  logic [NCH-1:0] sel_nxt;

  always_comb sel_nxt = sel_wr ? sel_data : sel_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign rise_mask[c]   = sel_wr & ~sel_q[c] & sel_data[c];
    assign reload_mask[c] = dac_wr & ~sel_nxt[c];
    assign ev_mask[c]     = rise_mask[c] | reload_mask[c];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= '1;
    else        sel_q <= sel_nxt;

  assert_dac_keeps_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr && !sel_wr |=> $stable(sel_q));
  assert_rise_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_mask & ~sel_data) == '0);
endmodule

// File: rtl/dpl_load_out.sv
module dpl_load_out #(
  parameter int unsigned NCH    = dpl_pkg::DEF_NCH,
  parameter int unsigned IDX_W  = dpl_pkg::DEF_IDX_W,
  parameter int unsigned CODE_W = dpl_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ev_mask,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [CODE_W-1:0] code_in,
  output logic              load_vld,
  output logic [NCH-1:0]    load_mask,
  output logic [IDX_W-1:0]  load_idx,
  output logic [CODE_W-1:0] load_code
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      load_vld  <= 1'b0;
      load_mask <= '0;
      load_idx  <= '0;
      load_code <= '0;
    end else begin
      load_vld  <= |ev_mask;
      load_mask <= ev_mask;
      if (|ev_mask) begin
        load_idx  <= idx_in;
        load_code <= code_in;
      end
    end

  assert_vld_has_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld == (load_mask != '0));
endmodule

// File: rtl/dac_param_loader.sv
module dac_param_loader #(
  parameter int unsigned DATA_W = dpl_pkg::DEF_DATA_W,
  parameter int unsigned CODE_W = dpl_pkg::DEF_CODE_W,
  parameter int unsigned LO_W   = dpl_pkg::DEF_LO_W,
  parameter int unsigned IDX_W  = dpl_pkg::DEF_IDX_W,
  parameter int unsigned NCH    = dpl_pkg::DEF_NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dac_wr,
  input  logic              dac_lsb,
  input  logic              idx_wr,
  input  logic              sel_wr,
  output logic              load_vld,
  output logic [NCH-1:0]    load_mask,
  output logic [IDX_W-1:0]  load_idx,
  output logic [CODE_W-1:0] load_code
);
  logic [CODE_W-1:0] code_q, code_nxt;
  logic [IDX_W-1:0]  idx_q, idx_nxt;
  logic [NCH-1:0]    sel_q, rise_mask, reload_mask, ev_mask;

  dpl_code_reg #(.DATA_W(DATA_W), .CODE_W(CODE_W), .LO_W(LO_W)) u_code (
    .clk(clk), .rst_n(rst_n), .wr_en(dac_wr), .half_sel(dac_lsb),
    .wr_data(wr_data), .code_q(code_q), .code_nxt(code_nxt));

  always_comb idx_nxt = idx_wr ? wr_data[IDX_W-1:0] : idx_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_nxt;

  dpl_sel_track #(.NCH(NCH)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .dac_wr(dac_wr),
    .sel_data(wr_data[NCH-1:0]), .sel_q(sel_q), .rise_mask(rise_mask),
    .reload_mask(reload_mask), .ev_mask(ev_mask));

  dpl_load_out #(.NCH(NCH), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ev_mask(ev_mask), .idx_in(idx_nxt),
    .code_in(code_nxt), .load_vld(load_vld), .load_mask(load_mask),
    .load_idx(load_idx), .load_code(load_code));

  assert_full_sel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr && !sel_wr && (sel_q == '1) |=> !load_vld);
  assert_index_carried_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr && (ev_mask != '0) |=> load_idx == $past(wr_data[IDX_W-1:0]));
  assert_rise_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && ((~sel_q & wr_data[NCH-1:0]) != '0) |=> load_vld);
  assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr && !sel_wr |=> !load_vld);
endmodule

// File: tb/dac_param_loader_tb.sv
module dac_param_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic dac_wr = 1'b0, dac_lsb = 1'b0, idx_wr = 1'b0, sel_wr = 1'b0;
  logic load_vld;
  logic [5:0] load_mask;
  logic [2:0] load_idx;
  logic [11:0] load_code;

  int checks = 0;
  int errors = 0;

  logic [5:0]  m_sel;
  logic [11:0] m_code;
  logic [2:0]  m_idx;
  logic [5:0]  e_mask;
  logic [11:0] e_code;
  logic [2:0]  e_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_param_loader dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .dac_wr(dac_wr),
    .dac_lsb(dac_lsb), .idx_wr(idx_wr), .sel_wr(sel_wr),
    .load_vld(load_vld), .load_mask(load_mask), .load_idx(load_idx),
    .load_code(load_code));

  function automatic logic [11:0] bench_code(input logic [11:0] c,
    input logic lsb, input logic [7:0] d);
    if (lsb) return {c[11:6], d[7:2]};
    return {d[5:0], c[5:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic dw, input logic lsb,
                      input logic iw, input logic sw, input logic [7:0] d);
    logic [5:0] new_sel;
    logic [5:0] mask;
    @(negedge clk);
    dac_wr = dw; dac_lsb = lsb; idx_wr = iw; sel_wr = sw; wr_data = d;
    if (dw) m_code = bench_code(m_code, lsb, d);
    if (iw) m_idx = d[2:0];
    new_sel = sw ? d[5:0] : m_sel;
    mask = (sw ? (new_sel & ~m_sel) : 6'h00) | (dw ? ~new_sel : 6'h00);
    m_sel = new_sel;
    if (mask != 0) begin e_idx = m_idx; e_code = m_code; end
    e_mask = mask;
    @(negedge clk);
    dac_wr = 1'b0; idx_wr = 1'b0; sel_wr = 1'b0;
    chk(tag, "load_vld", {31'd0, load_vld}, {31'd0, (mask != 0)});
    chk(tag, "load_mask", {26'd0, load_mask}, {26'd0, e_mask});
    if (mask != 0) begin
      chk(tag, "load_idx", {29'd0, load_idx}, {29'd0, e_idx});
      chk(tag, "load_code", {20'd0, load_code}, {20'd0, e_code});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_sel = 6'h3F; m_code = '0; m_idx = '0; e_code = '0; e_idx = '0;
    repeat (3) @(negedge clk);
    // R8: reset values observable at the ports
    chk("R8", "load_vld after reset", {31'd0, load_vld}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: DAC writes with all select bits high give no strobe
    step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 8'hA4);
    step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 8'h15);
    // R3: set index, then R4/R8 a rising select pulls codes formed since reset
    step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 8'hFD);
    step("R5", 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);   // all bits fall: no load
    step("R4", 1'b0, 1'b0, 1'b0, 1'b1, 8'h2A);   // bits 1,3,5 rise
    step("R5", 1'b0, 1'b0, 1'b0, 1'b1, 8'h2A);   // no change: no load
    // R1/R2/R6: DAC writes reload low channels (0,2,4)
    step("R1", 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
    step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'hC0);
    step("R6", 1'b1, 1'b0, 1'b0, 1'b0, 8'h3F);
    step("R4", 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF);   // upper bits ignored, 0,2,4 rise
    step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 8'h01);
    // R9: same-cycle select and DAC and index writes merge into one strobe
    step("R9", 1'b1, 1'b1, 1'b1, 1'b1, 8'h96);
    step("R9", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R9", r[0] & r[1], r[2], r[3] & r[4], r[5] & r[6], r[15:8]);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule